// File: doc/BRIEF.md
# Control Bit Majority Decoder

This block recovers four application control bits, named C1 to C4, from a stream of received frames. Each frame brings one sample of each bit and a sequence bit C0, presented for one clock on a frame strobe. The sequence bit repeats a 16-frame pattern: eight frames at 1, then eight frames at 0. A vote window opens on each 0-to-1 change of C0 and closes on the sixteenth counted frame. At the close, each bit is decided by majority. A tie of eight against eight keeps the bit's previous decision.

The four decided bits feed a status register unchanged. The four indicator pins have two modes, chosen by a mode input. With the mode at 0, pins 1 to 3 copy the decided C1 to C3. With the mode at 1, those pins become single-mono, dual-mono and stereo lamps. Pin 4 always copies the decided C4. The register that drives the mode input is expected to come out of reset at 1.

All pins stay dark until a full window has closed while frame alignment is held. Losing alignment clears the partial counts and darkens the pins again. The voted status bits are kept.

Top module: `ctrl_bit_vote`

## Requirements
- R1: At the close of a window, a bit whose sample was 1 in 9 or more of the 16 frames becomes 1 in `stat_bits`, one clock after the strobe of the sixteenth frame.
- R2: At the close of a window, a bit whose sample was 1 in 7 or fewer of the 16 frames becomes 0 in `stat_bits`.
- R3: A bit whose sample was 1 in exactly 8 of the 16 frames keeps its previous value in `stat_bits`.
- R4: Window boundaries follow C0. A window opens on a strobed frame with C0=1 whose previously strobed frame had C0=0, and closes on its sixteenth strobed frame. Frames are not counted until the first such opening after reset or realignment. A new 0-to-1 change of C0 inside an open window discards the partial counts and restarts the window at that frame.
- R5: Frame inputs are sampled only in cycles where `frame_stb` is 1. Values on `frame_c0` and `frame_cbits` in other cycles do not affect any decision.
- R6: With `pin_mode` at 0 and a window closed since alignment, `ind_pins[2:0]` equal `stat_bits[2:0]` and `ind_pins[3]` equals `stat_bits[3]`.
- R7: With `pin_mode` at 1, the decided C1,C2,C3 are decoded as a code. The bit encoding is bit 0 = C1, bit 1 = C2, bit 2 = C3, bit 3 = C4 in both `frame_cbits` and `stat_bits`. C1=1,C2=0,C3=0 lights only `ind_pins[0]` (single mono). C1=0,C2=1,C3=0 lights only `ind_pins[1]` (dual mono). C1=0,C2=0,C3=0 lights only `ind_pins[2]` (stereo). Any other code lights none of `ind_pins[2:0]`. `ind_pins[3]` still copies C4.
- R8: `stat_bits`, and `ind_pins[3]`, do not depend on `pin_mode`. Changing `pin_mode` alters only `ind_pins[2:0]`, in the same cycle.
- R9: After reset, `stat_bits` and `ind_pins` are 0. `ind_pins` stay 0 until the first window closes.
- R10: When `align_ok` is 0 at a clock edge, the partial window is discarded and `ind_pins` read 0 from that edge on. `stat_bits` keep their values. Counting resumes only after a new 0-to-1 change of C0 once `align_ok` is back at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe, one per received frame |
| frame_c0 | input | 1 | Sequence bit C0 of the strobed frame |
| frame_cbits | input | 4 | C1..C4 samples of the strobed frame (bit 0 = C1) |
| align_ok | input | 1 | Frame alignment held |
| pin_mode | input | 1 | 0 = pins copy bits, 1 = pins show decoded sound mode |
| stat_bits | output | 4 | Voted C1..C4 for the status register (bit 0 = C1) |
| ind_pins | output | 4 | Indicator pins 1..4 (bit 0 = pin 1) |

## Verification
The vote is driven with per-bit counts of 16, 9, 8, 7 and 0 ones per window. This separates set, clear and tie-hold at the exact threshold, and each bit gets a different count in the same window so crossed lanes show. One window carries all-ones noise and toggling C0 between strobes, to show that only strobed frames count. A window interrupted by an early C0 rise tells a restarting window apart from a free-running 16-frame count. An alignment drop in mid-window tells cleared counts apart from kept ones, because the frames that follow would otherwise complete a vote. Decoded pins are tried on the single, dual, stereo and two invalid codes, and the mode is flipped on settled bits.

// File: rtl/cbv_pkg.sv
`timescale 1ns/1ps
package cbv_pkg;

    localparam int CB_N = 4;

    typedef enum logic [1:0] {
        SND_STEREO,
        SND_DUAL,
        SND_SINGLE,
        SND_NONE
    } snd_mode_e;

    // code[0]=C1, code[1]=C2, code[2]=C3
    function automatic snd_mode_e decode_sound(input logic [2:0] code);
        case (code)
            3'b000:  decode_sound = SND_STEREO;
            3'b010:  decode_sound = SND_DUAL;
            3'b001:  decode_sound = SND_SINGLE;
            default: decode_sound = SND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cbv_seq_tracker.sv
`timescale 1ns/1ps
module cbv_seq_tracker #(
    parameter int SEQ_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic c0_i,
    input  logic align_i,
    output logic en_o,
    output logic start_o,
    output logic close_o,
    output logic clr_o,
    output logic valid_o
);
    localparam int IDX_W = $clog2(SEQ_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic             prev_c0;
        logic [IDX_W-1:0] idx;
        logic             valid;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rise;

    always_comb begin
        trk_d   = trk_q;
        en_o    = 1'b0;
        start_o = 1'b0;
        close_o = 1'b0;
        clr_o   = ~align_i;
        rise    = c0_i & ~trk_q.prev_c0;
        if (!align_i) begin
            trk_d.prev_c0 = 1'b1;
            trk_d.idx     = '0;
            trk_d.valid   = 1'b0;
        end else if (strobe_i) begin
            trk_d.prev_c0 = c0_i;
            if (rise) begin
                en_o      = 1'b1;
                start_o   = 1'b1;
                trk_d.idx = IDX_W'(1);
            end else if (trk_q.idx != '0) begin
                en_o = 1'b1;
                if (trk_q.idx == LAST_IDX) begin
                    close_o     = 1'b1;
                    trk_d.idx   = '0;
                    trk_d.valid = 1'b1;
                end else begin
                    trk_d.idx = trk_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{prev_c0: 1'b1, idx: '0, valid: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign valid_o = trk_q.valid;

    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !align_i |=> !valid_o);

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(strobe_i && align_i));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (align_i && strobe_i && c0_i && !trk_q.prev_c0) |=> (trk_q.idx == IDX_W'(1)));

endmodule

// File: rtl/cbv_bit_counter.sv
`timescale 1ns/1ps
module cbv_bit_counter #(
    parameter int SEQ_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic start_i,
    input  logic close_i,
    input  logic sample_i,
    output logic voted_o
);
    localparam int CNT_W = $clog2(SEQ_LEN + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(SEQ_LEN / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             voted;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] tot;

    always_comb begin
        cnt_d = cnt_q;
        tot   = (start_i ? '0 : cnt_q.cnt) + CNT_W'(sample_i);
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (en_i) begin
            if (close_i) begin
                cnt_d.cnt = '0;
                if (tot > HALF) begin
                    cnt_d.voted = 1'b1;
                end else if (tot < HALF) begin
                    cnt_d.voted = 1'b0;
                end
            end else begin
                cnt_d.cnt = tot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign voted_o = cnt_q.voted;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.cnt < CNT_W'(SEQ_LEN));

    assert_change_at_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.voted != $past(cnt_q.voted)) |-> $past(en_i && close_i && !clr_i));

    assert_tie_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && close_i && !clr_i && tot == HALF) |=> $stable(voted_o));

endmodule

// File: rtl/cbv_pin_map.sv
`timescale 1ns/1ps
module cbv_pin_map
    import cbv_pkg::*;
(
    input  logic [CB_N-1:0] voted_i,
    input  logic            valid_i,
    input  logic            mode_i,
    output logic [CB_N-1:0] pins_o
);
    snd_mode_e snd;

    always_comb begin
        snd    = decode_sound(voted_i[2:0]);
        pins_o = '0;
        if (valid_i) begin
            pins_o[3] = voted_i[3];
            if (!mode_i) begin
                pins_o[2:0] = voted_i[2:0];
            end else begin
                case (snd)
                    SND_SINGLE: pins_o[0] = 1'b1;
                    SND_DUAL:   pins_o[1] = 1'b1;
                    SND_STEREO: pins_o[2] = 1'b1;
                    default:    pins_o[2:0] = 3'b000;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctrl_bit_vote.sv
`timescale 1ns/1ps
module ctrl_bit_vote
    import cbv_pkg::*;
#(
    parameter int SEQ_LEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic            frame_c0,
    input  logic [CB_N-1:0] frame_cbits,
    input  logic            align_ok,
    input  logic            pin_mode,
    output logic [CB_N-1:0] stat_bits,
    output logic [CB_N-1:0] ind_pins
);
    logic en, start, close, clr, valid;

    cbv_seq_tracker #(.SEQ_LEN(SEQ_LEN)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (frame_stb),
        .c0_i     (frame_c0),
        .align_i  (align_ok),
        .en_o     (en),
        .start_o  (start),
        .close_o  (close),
        .clr_o    (clr),
        .valid_o  (valid)
    );

    for (genvar b = 0; b < CB_N; b++) begin : g_lane
        cbv_bit_counter #(.SEQ_LEN(SEQ_LEN)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .en_i     (en),
            .start_i  (start),
            .close_i  (close),
            .sample_i (frame_cbits[b]),
            .voted_o  (stat_bits[b])
        );
    end

    cbv_pin_map u_map (
        .voted_i (stat_bits),
        .valid_i (valid),
        .mode_i  (pin_mode),
        .pins_o  (ind_pins)
    );

    assert_pins_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (ind_pins == '0));

    assert_raw_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pin_mode) |-> (ind_pins[2:0] == stat_bits[2:0]));

    assert_lamp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |-> $onehot0(ind_pins[2:0]));

    assert_c4_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (ind_pins[3] == stat_bits[3]));

    assert_stat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(stat_bits));

endmodule

// File: tb/ctrl_bit_vote_bench.sv
`timescale 1ns/1ps
module ctrl_bit_vote_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_stb;
    logic       frame_c0;
    logic [3:0] frame_cbits;
    logic       align_ok;
    logic       pin_mode;
    logic [3:0] stat_bits;
    logic [3:0] ind_pins;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ctrl_bit_vote u_ctrl_bit_vote (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .frame_c0    (frame_c0),
        .frame_cbits (frame_cbits),
        .align_ok    (align_ok),
        .pin_mode    (pin_mode),
        .stat_bits   (stat_bits),
        .ind_pins    (ind_pins)
    );

    typedef struct packed {
        logic [4:0] k1;
        logic [4:0] k2;
        logic [4:0] k3;
        logic [4:0] k4;
        logic       mode;
        logic [3:0] stat;
        logic [3:0] pins;
    } vec_t;

    // ones-count per bit, mode, expected stat_bits, expected ind_pins
    localparam vec_t VEC [7] = '{
        '{5'd16, 5'd0,  5'd0,  5'd16, 1'b1, 4'b1001, 4'b1001},
        '{5'd0,  5'd9,  5'd0,  5'd7,  1'b1, 4'b0010, 4'b0010},
        '{5'd7,  5'd8,  5'd0,  5'd8,  1'b1, 4'b0010, 4'b0010},
        '{5'd0,  5'd0,  5'd0,  5'd9,  1'b1, 4'b1000, 4'b1100},
        '{5'd9,  5'd9,  5'd16, 5'd8,  1'b0, 4'b1111, 4'b1111},
        '{5'd8,  5'd0,  5'd9,  5'd0,  1'b1, 4'b0101, 4'b0000},
        '{5'd16, 5'd16, 5'd16, 5'd16, 1'b0, 4'b1111, 4'b1111}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic c0, input logic [3:0] cb);
        @(negedge clk);
        frame_stb   = 1'b1;
        frame_c0    = c0;
        frame_cbits = cb;
        @(negedge clk);
        frame_stb   = 1'b0;
        frame_cbits = 4'b0000;
    endtask

    task automatic idle_noise();
        repeat (2) begin
            @(negedge clk);
            frame_c0    = ~frame_c0;
            frame_cbits = 4'b1111;
        end
    endtask

    task automatic send_window(input int k1, input int k2, input int k3, input int k4,
                               input int nframes, input bit noisy);
        for (int f = 0; f < nframes; f++) begin
            send_frame(f < 8, {f < k4, f < k3, f < k2, f < k1});
            if (noisy) idle_noise();
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        frame_stb   = 1'b0;
        frame_c0    = 1'b0;
        frame_cbits = 4'b0000;
        align_ok    = 1'b1;
        pin_mode    = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset stat", stat_bits, 4'b0000);
        check("R9 reset pins", ind_pins, 4'b0000);
        pin_mode = 1'b0;
        #1;
        check("R9 reset pins mode0", ind_pins, 4'b0000);

        // C0=1 frames before any 0-to-1 change are not counted; partial window closes nothing
        repeat (3) send_frame(1'b1, 4'b1111);
        send_frame(1'b0, 4'b1111);
        send_window(16, 16, 16, 16, 10, 1'b0);
        check("R9 R4 pre-lock stat", stat_bits, 4'b0000);
        check("R9 pre-lock pins", ind_pins, 4'b0000);

        // table: R1 R2 R3 vote, R6 R7 pins, entry 1 noisy for R5
        for (int i = 0; i < 7; i++) begin
            pin_mode = VEC[i].mode;
            send_window(int'(VEC[i].k1), int'(VEC[i].k2), int'(VEC[i].k3), int'(VEC[i].k4),
                        16, i == 1);
            #1;
            check($sformatf("R1 R2 R3 R5 vec%0d stat", i), stat_bits, VEC[i].stat);
            check($sformatf("R6 R7 vec%0d pins", i), ind_pins, VEC[i].pins);
        end

        // R8: mode change alters only decoded pins
        pin_mode = 1'b1;
        #1;
        check("R7 invalid code pins", ind_pins, 4'b1000);
        check("R8 stat under mode1", stat_bits, 4'b1111);
        pin_mode = 1'b0;
        #1;
        check("R8 pins back in mode0", ind_pins, 4'b1111);

        // R4: a C0 rise inside an open window restarts it
        send_window(0, 16, 16, 16, 16, 1'b0);
        check("R2 C1 cleared", stat_bits, 4'b1110);
        for (int f = 0; f < 5; f++) send_frame(1'b1, 4'b0001);
        send_frame(1'b0, 4'b0001);
        send_window(3, 16, 16, 16, 16, 1'b0);
        check("R4 restart stat", stat_bits, 4'b1110);
        check("R6 restart pins", ind_pins, 4'b1110);

        // R10: alignment loss in mid-window
        send_window(16, 16, 16, 16, 8, 1'b0);
        @(negedge clk);
        align_ok = 1'b0;
        @(negedge clk);
        check("R10 pins dark", ind_pins, 4'b0000);
        check("R10 stat kept", stat_bits, 4'b1110);
        align_ok = 1'b1;
        for (int f = 0; f < 8; f++) send_frame(1'b0, 4'b1111);
        check("R10 no close after realign", stat_bits, 4'b1110);
        check("R10 pins still dark", ind_pins, 4'b0000);
        send_window(16, 0, 0, 0, 16, 1'b0);
        check("R10 R1 relock stat", stat_bits, 4'b0001);
        check("R10 R6 relock pins", ind_pins, 4'b0001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule